// File: doc/BRIEF.md
# Processor Clock Source Select and Divide

This block produces the clock-enable stream for a processor subsystem. It works in one reference clock domain. Each of four candidate sources is an enable strobe that is high for one reference cycle per source period. A 32-bit control word chooses one source and sets two divide ratios. Only the highest-numbered source goes through a 1-to-32 pre-divider. After that, a 1-to-4 post-divider shapes the final enable pulse train. The other three sources skip the pre-divider entirely.

Software writes the control word over a plain write-enable register port and reads it back unchanged. A new setting does not reach the clock path at once. It waits for the output period in progress to complete, so a reprogrammed ratio never produces a shortened period. The output strobe is registered. It appears one reference cycle after the source strobe that completes an output period.

Top module: `pclk_mux_div`

## Requirements
- R1: After reset the read-back word is 0 (source 0, both divide fields 0) and the output strobe is low.
- R2: A write stores all 32 bits, and the read-back port shows the written word from the cycle after the write.
- R3: Bits 17:16 select which of the four source strobes is used. Strobes on the unselected sources have no effect on the output.
- R4: For sources 0, 1 and 2 the pre-divide field has no effect. The output rate is the source rate divided by (bits 5:4 + 1).
- R5: For source 3 the output rate is the source rate divided by (bits 12:8 + 1) and then by (bits 5:4 + 1).
- R6: The post-divide field in bits 5:4 divides the selected stream by 1 to 4.
- R7: When both divide fields are 0, every strobe on the selected source produces an output strobe.
- R8: A new select or divide setting takes effect only in the cycle that ends the current output period. The period in progress finishes with the old setting.
- R9: Bits outside 17:16, 12:8 and 5:4 are stored and read back but do not change the output.
- R10: The output strobe is high for exactly the reference cycle that follows the source strobe closing an output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word to store |
| cfg_rd_data | output | 32 | Stored control word |
| src_tick | input | 4 | One enable strobe per source |
| clk_en_o | output | 1 | Divided output enable strobe |

## Verification
The bench reprograms the block in the middle of an output period. A design that applied the change at once would emit an early pulse. The bench checks that the old period still runs to its full length. It also sets a large pre-divide value while a low-numbered source is selected; a design that did not bypass the pre-divider would then emit far fewer pulses than expected. It drives strobes only on the unselected sources, to catch a faulty mux that leaks them to the output. Finally, it writes a word with every unused bit set and expects plain pass-through, which fails if a field is decoded from the wrong bit position.

// File: rtl/pmd_pkg.sv
// Package: control word layout and the decoded setting type shared by the
// divider blocks and the checker. Field positions are fixed by software.
package pmd_pkg;
    localparam int REG_W    = 32;
    localparam int SEL_LSB  = 16;
    localparam int SEL_W    = 2;
    localparam int PRE_LSB  = 8;
    localparam int PRE_W    = 5;
    localparam int POST_LSB = 4;
    localparam int POST_W   = 2;

    // Decoded setting that drives the clock path.
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } pmd_cfg_t;
endpackage

// File: rtl/pmd_cfg_reg.sv
// Module: control word storage plus the active setting used by the clock path.
// Assumes: period_end is high for exactly the cycle that closes an output period;
// the active setting reloads only then, so a ratio never changes mid-period.
module pmd_cfg_reg
    import pmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             period_end,
    output logic [REG_W-1:0] rd_data,
    output pmd_cfg_t         act_cfg
);
    logic [REG_W-1:0] word_q;
    pmd_cfg_t         decoded;

    // Hold the full software-visible word.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (wr_en) word_q <= wr_data;
    end

    // Pull the three fields out of the stored word.
    always_comb begin
        decoded.sel  = word_q[SEL_LSB +: SEL_W];
        decoded.pre  = word_q[PRE_LSB +: PRE_W];
        decoded.post = word_q[POST_LSB +: POST_W];
    end

    // Reload the active setting only at an output period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_cfg <= '0;
        else if (period_end) act_cfg <= decoded;
    end

    assign rd_data = word_q;
endmodule

// File: rtl/pmd_src_sel.sv
// Module: picks the strobe of the selected source out of N strobes.
// Assumes: sel is stable within an output period (guaranteed by pmd_cfg_reg).
module pmd_src_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               sel_tick
);
    logic [NUM_SRC-1:0] hit;

    // One gated term per source, OR-reduced below.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_tick[g] & (sel == SEL_W'(g));
    end

    assign sel_tick = |hit;
endmodule

// File: rtl/pmd_divider.sv
// Module: strobe divider; passes every (ratio+1)-th input strobe.
// Assumes: ratio_i changes only while the count is zero or together with clear_i.
module pmd_divider #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic             clear_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = tick_i & (cnt_q == ratio_i);

    // Count input strobes, wrap on the terminal strobe or on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear_i || done_o) cnt_q <= '0;
        else if (tick_i)           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pclk_mux_div.sv
// Module: processor clock-enable generator: source select, optional pre-divide
// on one source, post-divide, registered output strobe.
// Assumes: sources are one-cycle enable strobes in the clk domain; settings
// written through cfg_wr_* apply at the end of the running output period.
module pclk_mux_div
    import pmd_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int PRE_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [REG_W-1:0]   cfg_wr_data,
    output logic [REG_W-1:0]   cfg_rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               clk_en_o
);
    localparam logic [SEL_W-1:0] PRE_IDX = SEL_W'(PRE_SRC);

    pmd_cfg_t act_cfg;
    logic     sel_tick;
    logic     use_pre;
    logic     pre_done;
    logic     stage_tick;
    logic     period_end;
    logic     out_q;

    pmd_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .period_end (period_end),
        .rd_data    (cfg_rd_data),
        .act_cfg    (act_cfg)
    );

    pmd_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .src_tick (src_tick),
        .sel      (act_cfg.sel),
        .sel_tick (sel_tick)
    );

    assign use_pre = (act_cfg.sel == PRE_IDX);

    // Pre-divider exists only when the chosen source index is in range.
    if (PRE_SRC < NUM_SRC) begin : g_pre
        pmd_divider #(.CNT_W(PRE_W)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (sel_tick & use_pre),
            .ratio_i (act_cfg.pre),
            .clear_i (period_end),
            .done_o  (pre_done)
        );
    end else begin : g_no_pre
        assign pre_done = 1'b0;
    end

    assign stage_tick = use_pre ? pre_done : sel_tick;

    pmd_divider #(.CNT_W(POST_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (stage_tick),
        .ratio_i (act_cfg.post),
        .clear_i (1'b0),
        .done_o  (period_end)
    );

    // Register the output strobe so it is glitch-free at the port.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= period_end;
    end

    assign clk_en_o = out_q;
endmodule

// File: rtl/pmd_checker.sv
// Module: protocol checks for pclk_mux_div, attached through bind.
module pmd_checker
    import pmd_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [REG_W-1:0]   cfg_wr_data,
    input  logic [REG_W-1:0]   cfg_rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               clk_en_o,
    input  logic               sel_tick,
    input  pmd_cfg_t           act_cfg
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rd_data == '0) && !clk_en_o); // R1
    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data)); // R2
    AST_SELECTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o |-> $past(sel_tick)); // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.pre == '0 && act_cfg.post == '0 && sel_tick) |=> clk_en_o); // R7
    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> clk_en_o); // R8
endmodule

bind pclk_mux_div pmd_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .src_tick    (src_tick),
    .clk_en_o    (clk_en_o),
    .sel_tick    (sel_tick),
    .act_cfg     (act_cfg)
);

// File: tb/tb_pclk_mux_div.sv
module tb_pclk_mux_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [3:0]  src_tick = '0;
    logic        clk_en_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done_flag = 0;
    bit last_dn = 0;

    // Reference model state, built from the requirements.
    logic [31:0] m_reg = '0;
    int m_sel = 0, m_pre = 0, m_post = 0, m_pcnt = 0, m_qcnt = 0;

    pclk_mux_div dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .src_tick(src_tick), .clk_en_o(clk_en_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // One reference cycle: drive at negedge, predict, compare one edge later.
    task automatic step(input bit wr, input logic [31:0] d, input logic [3:0] t, input string tag);
        bit st, stg, dn;
        cfg_wr_en = wr; cfg_wr_data = d; src_tick = t;
        st  = t[m_sel];
        stg = (m_sel == 3) ? (st && m_pcnt == m_pre) : st;
        dn  = stg && (m_qcnt == m_post);
        if (m_sel == 3 && st) m_pcnt = (m_pcnt == m_pre) ? 0 : m_pcnt + 1;
        if (dn) m_pcnt = 0;
        if (dn) m_qcnt = 0; else if (stg) m_qcnt++;
        if (dn) begin
            m_sel = int'(m_reg[17:16]); m_pre = int'(m_reg[12:8]); m_post = int'(m_reg[5:4]);
        end
        if (wr) m_reg = d;
        last_dn = dn;
        @(negedge clk);
        chk(clk_en_o === dn, tag, {31'd0, clk_en_o}, {31'd0, dn});
        chk(cfg_rd_data === m_reg, tag, cfg_rd_data, m_reg);
        if (clk_en_o) pulses++;
        cfg_wr_en = 1'b0; src_tick = '0;
    endtask

    // Write a word, then run all sources until it is active at a period start.
    task automatic apply_cfg(input logic [31:0] d, input string tag);
        step(1'b1, d, 4'h0, tag);
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 32'h0, 4'hF, tag);
            if (last_dn) break;
        end
        pulses = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd_data === 32'h0, "R1", cfg_rd_data, 32'h0);
        chk(clk_en_o === 1'b0, "R1", {31'd0, clk_en_o}, 32'h0);
    endtask

    task automatic t_readback();
        step(1'b1, 32'hDEADBEEF, 4'h0, "R2");
        chk(cfg_rd_data === 32'hDEADBEEF, "R2", cfg_rd_data, 32'hDEADBEEF);
        apply_cfg(32'h0, "R2");
    endtask

    task automatic t_pass();
        step(1'b0, 0, 4'h1, "R7 R10");
        step(1'b0, 0, 4'h0, "R7 R10");
        for (int i = 0; i < 3; i++) step(1'b0, 0, 4'h1, "R7");
        chk(pulses == 4, "R7", pulses, 4);
        pulses = 0;
    endtask

    task automatic t_post();
        apply_cfg(32'h0001_0030, "R6");
        for (int i = 0; i < 12; i++) step(1'b0, 0, 4'h2, "R6");
        chk(pulses == 3, "R6", pulses, 3);
    endtask

    task automatic t_select();
        apply_cfg(32'h0002_0000, "R3");
        for (int i = 0; i < 8; i++) step(1'b0, 0, 4'b1011, "R3");
        chk(pulses == 0, "R3", pulses, 0);
        for (int i = 0; i < 3; i++) step(1'b0, 0, 4'b0100, "R3");
        chk(pulses == 3, "R3", pulses, 3);
    endtask

    task automatic t_pre();
        apply_cfg(32'h0003_0410, "R5");
        for (int i = 0; i < 40; i++) step(1'b0, 0, 4'h8, "R5");
        chk(pulses == 4, "R5", pulses, 4);
        apply_cfg(32'h0000_0710, "R4");
        for (int i = 0; i < 20; i++) step(1'b0, 0, 4'h1, "R4");
        chk(pulses == 10, "R4", pulses, 10);
    endtask

    task automatic t_other_bits();
        apply_cfg(32'hFFFC_E0CF, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, 0, 4'h1, "R9");
        chk(pulses == 6, "R9", pulses, 6);
        chk(cfg_rd_data === 32'hFFFC_E0CF, "R9", cfg_rd_data, 32'hFFFC_E0CF);
    endtask

    task automatic t_no_runt();
        apply_cfg(32'h0000_0030, "R8");
        step(1'b0, 0, 4'h1, "R8");
        step(1'b0, 0, 4'h1, "R8");
        step(1'b1, 32'h0, 4'h0, "R8");
        step(1'b0, 0, 4'h1, "R8");
        chk(pulses == 0, "R8", pulses, 0);
        step(1'b0, 0, 4'h1, "R8");
        chk(pulses == 1, "R8", pulses, 1);
        for (int i = 0; i < 3; i++) step(1'b0, 0, 4'h1, "R8");
        chk(pulses == 4, "R8", pulses, 4);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_pass();
        t_post();
        t_select();
        t_pre();
        t_other_bits();
        t_no_runt();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule